// File: doc/BRIEF.md
# Outbound Write Queue with Burst Merging and Read Bypass

This block sits on the host-to-PCI path of a bridge. Host-side requests (writes and reads, each a Dword address and a Dword count) enter a small in-order queue. The queue presents one entry at a time to a simplified PCI-side master. When merging is switched on, a write that continues exactly where the newest queued write ends is folded into that write. The two then go out as one burst whose length is capped.

The PCI side answers every offered transaction in the same cycle. It can report no answer, completion, retry, or a disconnect after some Dwords. A read that was retried or cut short is marked stalled. When bypass is switched on, the write directly behind a stalled head read may be issued first. When bypass is off, the stalled read holds back everything behind it until it completes. A partly done transaction resumes at its first untransferred Dword.

A two-bit configuration register holds the merge enable and the bypass enable. Merging starts disabled and bypass starts enabled.

Top module: `owq_top`

## Requirements
- R1: After reset the queue is empty: `iss_valid`=0 and `req_ready`=1. Merging is off and bypass is on.
- R2: With merging on, an accepted write merges into the newest entry when four conditions hold. That entry is a write. The new `req_addr` equals that entry's address plus its length. The summed length is at most MAX_LEN. That entry is not receiving a response (`rsp_kind`≠0) in the same cycle. The result is one transaction with the summed length.
- R3: With merging off, every accepted request is issued as its own transaction with its own address and length.
- R4: A write whose merge would exceed MAX_LEN Dwords (default 8) opens a new entry, and no offered length is ever 0 or above MAX_LEN.
- R5: A write never merges across a read: if the newest entry is a read, the write opens a new entry.
- R6: `rsp_kind` encoding: 2'b00 no answer (nothing changes), 2'b01 complete (entry removed), 2'b10 retry (entry kept unchanged), 2'b11 disconnect after `rsp_cnt` Dwords. A disconnect with 0<N<length advances the address by N and cuts the length by N. N=0 acts as retry and N≥length acts as complete. A retry or disconnect of a read marks it stalled.
- R7: With bypass on, if the head entry is a stalled read and the second entry is a write, the write is offered with `iss_bypass`=1.
- R8: With bypass off, a stalled head read is offered again and nothing behind it is offered until it completes.
- R9: Reads keep their order among reads and writes keep their order among writes. A write passes only the one stalled read at the head.
- R10: `cfg_wr`=1 loads `cfg_combine` and `cfg_around` at the clock edge. They take effect from the next cycle.
- R11: `req_ready` is 1 exactly when fewer than DEPTH entries are held. A request offered while full is not accepted and is lost to the queue.
- R12: A request accepted at an edge becomes visible on the issue outputs in the cycle right after that edge, if it is the selected entry. A response applied at an edge is reflected on the issue outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Load the two enable bits |
| cfg_combine | input | 1 | New write-merge enable |
| cfg_around | input | 1 | New read-bypass enable |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Queue can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Dword start address |
| req_len | input | 4 | Dword count, 1 to MAX_LEN |
| iss_valid | output | 1 | A transaction is offered to the PCI side |
| iss_write | output | 1 | Offered transaction is a write |
| iss_addr | output | 16 | Offered Dword address |
| iss_len | output | 4 | Offered Dword count |
| iss_bypass | output | 1 | Offered write is passing a stalled read |
| rsp_kind | input | 2 | Response to the offered transaction |
| rsp_cnt | input | 4 | Dwords moved before a disconnect |

## Verification
The issue outputs depend on registered queue state only, so every result is due exactly one clock after the edge that caused it. This covers an accepted request, a merge, a response and a configuration load. The bench drives inputs and samples outputs at the falling edge. Before each rising edge it advances its own queue model by that edge's inputs, and at the next falling edge it compares the design with the model. Directed checks read the outputs at the falling edge following the stimulus edge.

// File: rtl/owq_pkg.sv
package owq_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_DONE  = 2'b01,
    RSP_RETRY = 2'b10,
    RSP_DISC  = 2'b11
  } owq_rsp_e;
endpackage

// File: rtl/owq_cfg.sv
module owq_cfg (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic cfg_combine,
  input  logic cfg_around,
  output logic comb_q,
  output logic wa_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      comb_q <= 1'b0;
      wa_q   <= 1'b1;
    end else if (cfg_wr) begin
      comb_q <= cfg_combine;
      wa_q   <= cfg_around;
    end
  end
endmodule

// File: rtl/owq_pick.sv
module owq_pick (
  input  logic has_two,
  input  logic head_wr,
  input  logic head_stl,
  input  logic second_wr,
  input  logic wa_en,
  output logic sel_second
);
  function automatic logic may_pass(input logic two, input logic hw, input logic hs,
                                    input logic sw, input logic en);
    return two && !hw && hs && sw && en;
  endfunction

  assign sel_second = may_pass(has_two, head_wr, head_stl, second_wr, wa_en);
endmodule

// File: rtl/owq_merge.sv
module owq_merge #(
  parameter int AW      = 16,
  parameter int LW      = 4,
  parameter int MAX_LEN = 8
) (
  input  logic          en,
  input  logic          req_fire,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          tail_ok,
  input  logic          tail_wr,
  input  logic          tail_busy,
  input  logic [AW-1:0] tail_addr,
  input  logic [LW-1:0] tail_len,
  output logic          merge
);
  function automatic logic [AW-1:0] end_of(input logic [AW-1:0] a, input logic [LW-1:0] l);
    return a + AW'(l);
  endfunction

  function automatic logic fits(input logic [LW-1:0] a, input logic [LW-1:0] b);
    return (int'(a) + int'(b)) <= MAX_LEN;
  endfunction

  assign merge = en && req_fire && req_wr && tail_ok && tail_wr && !tail_busy &&
                 (end_of(tail_addr, tail_len) == req_addr) && fits(tail_len, req_len);
endmodule

// File: rtl/owq_top.sv
module owq_top #(
  parameter int AW      = 16,
  parameter int MAX_LEN = 8,
  parameter int DEPTH   = 4,
  localparam int LW     = $clog2(MAX_LEN + 1),
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int IW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_combine,
  input  logic          cfg_around,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  output logic          iss_valid,
  output logic          iss_write,
  output logic [AW-1:0] iss_addr,
  output logic [LW-1:0] iss_len,
  output logic          iss_bypass,
  input  logic [1:0]    rsp_kind,
  input  logic [LW-1:0] rsp_cnt
);
  import owq_pkg::*;

  logic [AW-1:0] q_addr [DEPTH];
  logic [LW-1:0] q_len  [DEPTH];
  logic          q_wr   [DEPTH];
  logic          q_stl  [DEPTH];
  logic [CW-1:0] q_cnt;

  logic [AW-1:0] n_addr [DEPTH];
  logic [LW-1:0] n_len  [DEPTH];
  logic          n_wr   [DEPTH];
  logic          n_stl  [DEPTH];
  logic [CW-1:0] n_cnt;

  logic comb_q, wa_q;
  logic sel_second;
  logic [IW-1:0] sel_i, tail_i;
  logic merge_ev, push_ev, pop_ev, tail_busy, req_fire;
  logic head_stall_rd;
  logic [LW-1:0] head_len;
  owq_rsp_e kind;

  owq_cfg u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_combine(cfg_combine),
    .cfg_around(cfg_around), .comb_q(comb_q), .wa_q(wa_q)
  );

  owq_pick u_pick (
    .has_two(q_cnt > CW'(1)), .head_wr(q_wr[0]), .head_stl(q_stl[0]),
    .second_wr(q_wr[1]), .wa_en(wa_q), .sel_second(sel_second)
  );

  assign sel_i     = sel_second ? IW'(1) : IW'(0);
  assign tail_i    = IW'(q_cnt - CW'(1));
  assign kind      = owq_rsp_e'(rsp_kind);
  assign req_ready = q_cnt < CW'(DEPTH);
  assign req_fire  = req_valid && req_ready;
  assign iss_valid = q_cnt != '0;
  assign iss_write = q_wr[sel_i];
  assign iss_addr  = q_addr[sel_i];
  assign iss_len   = q_len[sel_i];
  assign iss_bypass = iss_valid && sel_second;
  assign tail_busy = iss_valid && (kind != RSP_NONE) && (sel_i == tail_i);
  assign head_stall_rd = !q_wr[0] && q_stl[0];
  assign head_len  = q_len[0];

  owq_merge #(.AW(AW), .LW(LW), .MAX_LEN(MAX_LEN)) u_merge (
    .en(comb_q), .req_fire(req_fire), .req_wr(req_write), .req_addr(req_addr),
    .req_len(req_len), .tail_ok(q_cnt != '0), .tail_wr(q_wr[tail_i]),
    .tail_busy(tail_busy), .tail_addr(q_addr[tail_i]), .tail_len(q_len[tail_i]),
    .merge(merge_ev)
  );

  assign push_ev = req_fire && !merge_ev;

  always_comb begin
    n_addr = q_addr;
    n_len  = q_len;
    n_wr   = q_wr;
    n_stl  = q_stl;
    n_cnt  = q_cnt;
    pop_ev = 1'b0;
    if (merge_ev) n_len[tail_i] = q_len[tail_i] + req_len;
    if (iss_valid) begin
      unique case (kind)
        RSP_DONE:  pop_ev = 1'b1;
        RSP_RETRY: if (!q_wr[sel_i]) n_stl[sel_i] = 1'b1;
        RSP_DISC: begin
          if (rsp_cnt == '0) begin
            if (!q_wr[sel_i]) n_stl[sel_i] = 1'b1;
          end else if (rsp_cnt >= q_len[sel_i]) begin
            pop_ev = 1'b1;
          end else begin
            n_addr[sel_i] = q_addr[sel_i] + AW'(rsp_cnt);
            n_len[sel_i]  = q_len[sel_i] - rsp_cnt;
            if (!q_wr[sel_i]) n_stl[sel_i] = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (pop_ev) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(sel_i)) begin
          n_addr[i] = n_addr[i+1];
          n_len[i]  = n_len[i+1];
          n_wr[i]   = n_wr[i+1];
          n_stl[i]  = n_stl[i+1];
        end
      end
      n_cnt = q_cnt - CW'(1);
    end
    if (push_ev) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == n_cnt) begin
          n_addr[i] = req_addr;
          n_len[i]  = req_len;
          n_wr[i]   = req_write;
          n_stl[i]  = 1'b0;
        end
      end
      n_cnt = n_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_addr[i] <= '0;
        q_len[i]  <= '0;
        q_wr[i]   <= 1'b0;
        q_stl[i]  <= 1'b0;
      end
    end else begin
      q_cnt  <= n_cnt;
      q_addr <= n_addr;
      q_len  <= n_len;
      q_wr   <= n_wr;
      q_stl  <= n_stl;
    end
  end
endmodule

// File: rtl/owq_chk.sv
module owq_chk #(
  parameter int MAX_LEN = 8,
  parameter int LW      = 4,
  parameter int CW      = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          iss_valid,
  input logic          iss_bypass,
  input logic [1:0]    rsp_kind,
  input logic          wa_q,
  input logic          comb_q,
  input logic          merge_ev,
  input logic          push_ev,
  input logic          pop_ev,
  input logic          head_stall_rd,
  input logic [LW-1:0] head_len,
  input logic [CW-1:0] q_cnt
);
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !pop_ev) |=> (q_cnt == $past(q_cnt)));

  p_bypass_stalled_r7: assert property (@(posedge clk) disable iff (rst)
    iss_bypass |-> (head_stall_rd && wa_q));

  p_no_bypass_off_r8: assert property (@(posedge clk) disable iff (rst)
    !wa_q |-> !iss_bypass);

  p_merge_enabled_r3: assert property (@(posedge clk) disable iff (rst)
    merge_ev |-> comb_q);

  p_merge_accepted_r2: assert property (@(posedge clk) disable iff (rst)
    merge_ev |-> (req_valid && req_ready));

  p_merge_no_grow_r2: assert property (@(posedge clk) disable iff (rst)
    (merge_ev && !pop_ev) |=> (q_cnt == $past(q_cnt)));

  p_len_cap_r4: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (head_len != '0 && int'(head_len) <= MAX_LEN));

  p_retry_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && rsp_kind == 2'b10 && !push_ev) |=> (q_cnt == $past(q_cnt)));
endmodule

bind owq_top owq_chk #(.MAX_LEN(MAX_LEN), .LW(LW), .CW(CW)) u_owq_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .iss_valid(iss_valid), .iss_bypass(iss_bypass), .rsp_kind(rsp_kind),
  .wa_q(wa_q), .comb_q(comb_q), .merge_ev(merge_ev), .push_ev(push_ev),
  .pop_ev(pop_ev), .head_stall_rd(head_stall_rd), .head_len(head_len), .q_cnt(q_cnt)
);

// File: tb/tb_owq_top.sv
`timescale 1ns/1ps
module tb_owq_top;
  localparam int DEPTH = 4;
  localparam int MAXL  = 8;
  localparam int AMASK = 16'hFFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_combine = 0, cfg_around = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic req_ready, iss_valid, iss_write, iss_bypass;
  logic [15:0] iss_addr;
  logic [3:0]  iss_len;
  logic [1:0]  rsp_kind = '0;
  logic [3:0]  rsp_cnt = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_n, m_c, m_wa;
  int m_a[DEPTH], m_l[DEPTH], m_w[DEPTH], m_s[DEPTH];

  always #10 clk = ~clk;

  owq_top dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_combine(cfg_combine),
    .cfg_around(cfg_around), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .iss_valid(iss_valid), .iss_write(iss_write), .iss_addr(iss_addr),
    .iss_len(iss_len), .iss_bypass(iss_bypass), .rsp_kind(rsp_kind), .rsp_cnt(rsp_cnt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_sel();
    if (m_n > 1 && m_w[0] == 0 && m_s[0] == 1 && m_wa == 1 && m_w[1] == 1) return 1;
    return 0;
  endfunction

  task automatic model_check();
    int s = m_sel();
    check(iss_valid == (m_n > 0), "R12 valid", int'(iss_valid), int'(m_n > 0));
    check(req_ready == (m_n < DEPTH), "R11 ready", int'(req_ready), int'(m_n < DEPTH));
    if (m_n > 0) begin
      check(iss_write == m_w[s], "R9 kind", int'(iss_write), m_w[s]);
      check(int'(iss_addr) == m_a[s], "R9 addr", int'(iss_addr), m_a[s]);
      check(int'(iss_len) == m_l[s], "R12 len", int'(iss_len), m_l[s]);
      check(int'(iss_bypass) == s, "R7 bypass", int'(iss_bypass), s);
    end
  endtask

  task automatic model_step(input bit rv, input bit rw, input int ra, input int rl,
                            input int rk, input int rc, input bit cw, input bit cc, input bit ca);
    int s = m_sel();
    bit valid = m_n > 0;
    bit fire = rv && (m_n < DEPTH);
    bit busy = valid && rk != 0 && s == m_n - 1;
    bit mrg = 0;
    bit pop = 0;
    if (fire && m_c == 1 && rw && m_n > 0)
      mrg = m_w[m_n-1] == 1 && ((m_a[m_n-1] + m_l[m_n-1]) & AMASK) == ra &&
            m_l[m_n-1] + rl <= MAXL && !busy;
    if (mrg) m_l[m_n-1] += rl;
    if (valid) begin
      case (rk)
        1: pop = 1;
        2: if (m_w[s] == 0) m_s[s] = 1;
        3: begin
          if (rc == 0) begin
            if (m_w[s] == 0) m_s[s] = 1;
          end else if (rc >= m_l[s]) pop = 1;
          else begin
            m_a[s] = (m_a[s] + rc) & AMASK;
            m_l[s] -= rc;
            if (m_w[s] == 0) m_s[s] = 1;
          end
        end
        default: ;
      endcase
    end
    if (pop) begin
      for (int i = s; i < m_n - 1; i++) begin
        m_a[i] = m_a[i+1]; m_l[i] = m_l[i+1]; m_w[i] = m_w[i+1]; m_s[i] = m_s[i+1];
      end
      m_n--;
    end
    if (fire && !mrg) begin
      m_a[m_n] = ra; m_l[m_n] = rl; m_w[m_n] = int'(rw); m_s[m_n] = 0;
      m_n++;
    end
    if (cw) begin m_c = int'(cc); m_wa = int'(ca); end
  endtask

  task automatic tick(input bit rv, input bit rw, input int ra, input int rl,
                      input int rk, input int rc, input bit cw, input bit cc, input bit ca);
    model_check();
    req_valid = rv; req_write = rw; req_addr = 16'(ra); req_len = 4'(rl);
    rsp_kind = 2'(rk); rsp_cnt = 4'(rc);
    cfg_wr = cw; cfg_combine = cc; cfg_around = ca;
    model_step(rv, rw, ra, rl, rk, rc, cw, cc, ca);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input bit rw, input int ra, input int rl);
    tick(1, rw, ra, rl, 0, 0, 0, 0, 0);
  endtask

  task automatic resp(input int rk, input int rc);
    tick(0, 0, 0, 1, rk, rc, 0, 0, 0);
  endtask

  task automatic cfg(input bit cc, input bit ca);
    tick(0, 0, 0, 1, 0, 0, 1, cc, ca);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int last_end = 0;
    int drained = 0;
    void'($urandom(32'd7));
    m_n = 0; m_c = 0; m_wa = 1;
    for (int i = 0; i < DEPTH; i++) begin m_a[i] = 0; m_l[i] = 0; m_w[i] = 0; m_s[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(iss_valid == 0, "R1 empty after reset", int'(iss_valid), 0);
    check(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);

    // R1 R3: merging off by default, sequential writes stay separate
    put(1, 'h10, 2);
    put(1, 'h12, 1);
    check(iss_addr == 'h10 && iss_len == 2, "R3 first write unmerged", int'(iss_len), 2);
    resp(1, 0);
    check(iss_addr == 'h12 && iss_len == 1, "R3 second write own entry", int'(iss_addr), 'h12);
    resp(1, 0);
    check(iss_valid == 0, "R3 queue drained", int'(iss_valid), 0);

    // R10 R2 R4: enable merging, merge up to MAX_LEN
    cfg(1, 1);
    put(1, 'h20, 3);
    put(1, 'h23, 2);
    check(iss_addr == 'h20 && iss_len == 5, "R2 merged burst length", int'(iss_len), 5);
    check(iss_len == 5, "R10 merge enable took effect", int'(iss_len), 5);
    put(1, 'h25, 4);
    check(iss_len == 5, "R4 overflowing write not merged", int'(iss_len), 5);
    resp(1, 0);
    check(iss_addr == 'h25 && iss_len == 4, "R4 new entry after cap", int'(iss_len), 4);
    resp(1, 0);

    // R5: no merge across a read
    put(1, 'h40, 1);
    put(0, 'h41, 1);
    put(1, 'h41, 1);
    check(iss_addr == 'h40 && iss_len == 1, "R5 head write alone", int'(iss_len), 1);
    resp(1, 0);
    check(iss_write == 0 && iss_addr == 'h41, "R5 read in between", int'(iss_write), 0);
    resp(1, 0);
    check(iss_write == 1 && iss_addr == 'h41 && iss_len == 1, "R5 write after read", int'(iss_len), 1);
    resp(1, 0);

    // R7 R6: bypass of a retried read, then partial resume
    put(0, 'h60, 4);
    put(1, 'h70, 1);
    check(iss_write == 0 && iss_bypass == 0, "R7 read first before stall", int'(iss_bypass), 0);
    resp(2, 0);
    check(iss_write == 1 && iss_addr == 'h70 && iss_bypass == 1, "R7 write passes stalled read", int'(iss_bypass), 1);
    resp(1, 0);
    check(iss_write == 0 && iss_addr == 'h60 && iss_len == 4, "R6 retry keeps read", int'(iss_len), 4);
    resp(3, 1);
    check(iss_addr == 'h61 && iss_len == 3, "R6 disconnect resumes", int'(iss_addr), 'h61);
    resp(0, 0);
    check(iss_addr == 'h61 && iss_len == 3, "R6 no answer changes nothing", int'(iss_len), 3);
    resp(3, 5);
    check(iss_valid == 0, "R6 long disconnect completes", int'(iss_valid), 0);

    // R8: bypass disabled
    cfg(1, 0);
    put(0, 'h80, 2);
    put(1, 'h90, 1);
    resp(2, 0);
    check(iss_write == 0 && iss_addr == 'h80 && iss_bypass == 0, "R8 stalled read blocks", int'(iss_write), 0);
    resp(1, 0);
    check(iss_write == 1 && iss_addr == 'h90, "R8 write after read done", int'(iss_addr), 'h90);
    resp(1, 0);
    cfg(1, 1);

    // R11: fill and overflow attempt
    for (int i = 0; i < DEPTH; i++) put(1, 'hA00 + 'h10 * i, 1);
    check(req_ready == 0, "R11 full not ready", int'(req_ready), 0);
    put(1, 'hB00, 1);
    drained = 0;
    for (int i = 0; i < 10; i++) begin
      if (iss_valid) drained++;
      resp(1, 0);
    end
    check(drained == DEPTH, "R11 overflow request dropped", drained, DEPTH);

    // R9 R12: constrained random against the model
    for (int it = 0; it < 4000; it++) begin
      bit rv = ($urandom % 3) != 0;
      bit rw = ($urandom % 3) != 0;
      int rl = 1 + int'($urandom % 4);
      int ra = (($urandom % 2) == 1) ? last_end : int'($urandom % 256);
      int rk = int'($urandom % 4);
      int rc = int'($urandom % 6);
      bit cw = ($urandom % 50) == 0;
      bit cc = ($urandom % 4) != 0;
      bit ca = ($urandom % 3) != 0;
      if (rv && rw) last_end = (ra + rl) & AMASK;
      tick(rv, rw, ra, rl, rk, rc, cw, cc, ca);
    end
    for (int i = 0; i < 12; i++) resp(1, 0);
    check(iss_valid == 0, "R9 all drained", int'(iss_valid), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule